// File: doc/BRIEF.md
# Bus Hold Time Limiter

This block caps how long the local processor may keep ownership of a shared multiprocessor bus. It works next to the bus arbiter and is indifferent to the arbitration scheme, fixed or rotating. Software programs a limit register. Each time the processor wins the bus, a down-counter is loaded from that register. The counter then spends one unit for every cycle in which the processor moves data over the bus while some other processor is waiting for it.

When the budget is exhausted, a release output tells the bus-request logic to drop the local request, so the waiting processors can win arbitration. The programmed value is the allowed hold time in clock cycles, less two. A value of 0 turns the limit off. A value of 1 has no meaning and is refused. Both the limit and the live count can be read back through a small register port.

Top module: `bus_hold_limiter`

## Requirements
- R1: After reset the limit register reads 0, the count reads 0, `count_o` is 0 and `release_o` is 0.
- R2: A write (`wr_en_i` high) of any value other than 1 replaces the limit register, and the new value is visible on `rd_data_o` with `rd_sel_i`=0 from the cycle after the write.
- R3: A write of the value 1 is discarded, and the limit register keeps its previous contents.
- R4: While `req_level_i` is high, a cycle with `acquire_i` high loads the count with the limit register value, visible on the next cycle.
- R5: While `req_level_i` is high and `acquire_i` is low, the count drops by exactly one after each cycle in which `xfer_i` and `others_req_i` are both high, the count is nonzero and the limit is nonzero. In every other such cycle the count holds, including a transfer with no other requester.
- R6: A cycle with `req_level_i` low reloads the count from the limit register, visible on the next cycle.
- R7: With a nonzero limit, `release_o` rises combinationally in the cycle in which `req_level_i`, `xfer_i` and `others_req_i` are high, `acquire_i` is low and the count is already 0. With limit 2 this happens on the third such qualifying cycle after acquisition, so the bus is held for four cycles.
- R8: Once asserted, `release_o` stays high until `req_level_i` goes low, and it is low in every cycle in which `req_level_i` is low.
- R9: With the limit register at 0, `release_o` never asserts and the count stays at 0 after a load.
- R10: `rd_data_o` shows the limit register when `rd_sel_i`=0 and the live count when `rd_sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the limit register |
| wr_data_i | input | CNT_W | Value to write into the limit register |
| rd_sel_i | input | 1 | Readback select: 0 limit, 1 count |
| rd_data_o | output | CNT_W | Readback data |
| acquire_i | input | 1 | One-cycle pulse when the processor wins the bus |
| xfer_i | input | 1 | Processor performs a bus read or write this cycle |
| others_req_i | input | 1 | At least one other processor is requesting the bus |
| req_level_i | input | 1 | Local bus-request level |
| count_o | output | CNT_W | Current remaining budget |
| release_o | output | 1 | Forces the local bus request to drop |

## Verification
The assertions assume that `acquire_i` arrives only while `req_level_i` is high, and that the inputs are free of X once reset is released. The stimulus meets this by raising the request before it pulses acquisition in every scenario. It changes inputs only some time after the clock edge. It writes the limit register only while the processor does not hold the bus, so each countdown runs against a fixed budget.

// File: rtl/bhl_pkg.sv
package bhl_pkg;

  typedef enum logic [1:0] {
    CA_HOLD = 2'd0,
    CA_LOAD = 2'd1,
    CA_DEC  = 2'd2
  } cnt_act_e;

  localparam int unsigned BHL_REFUSED_VALUE = 1;

  // A limit value is accepted unless it is the reserved code.
  function automatic logic bhl_write_accepted(input int unsigned value);
    return value != BHL_REFUSED_VALUE;
  endfunction

  // Counter action chosen from the request level and the transfer events.
  function automatic cnt_act_e bhl_pick_action(input logic req_level,
                                                input logic acquire,
                                                input logic qual_xfer,
                                                input logic enabled,
                                                input logic at_zero);
    if (!req_level)                            return CA_LOAD;
    else if (acquire)                          return CA_LOAD;
    else if (qual_xfer && enabled && !at_zero) return CA_DEC;
    else                                       return CA_HOLD;
  endfunction

  // Budget exhausted: a qualifying transfer arrives with nothing left.
  function automatic logic bhl_expired(input logic req_level,
                                       input logic acquire,
                                       input logic qual_xfer,
                                       input logic enabled,
                                       input logic at_zero);
    return req_level && !acquire && qual_xfer && enabled && at_zero;
  endfunction

endpackage

// File: rtl/bhl_limit_reg.sv
module bhl_limit_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             enabled_o
);
  import bhl_pkg::*;

  logic [CNT_W-1:0] limit_q;
  logic             wr_accept;

  assign wr_accept = wr_en_i && bhl_write_accepted(32'(wr_data_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        limit_q <= '0;
    else if (wr_accept) limit_q <= wr_data_i;
  end

  assign limit_o   = limit_q;
  assign enabled_o = (limit_q != '0);

  p_refused_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == CNT_W'(1)) |=> $stable(limit_o));

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != CNT_W'(1)) |=> (limit_o == $past(wr_data_i)));

  p_no_write_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(limit_o));

endmodule

// File: rtl/bhl_counter.sv
module bhl_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             enabled_i,
  input  logic             req_level_i,
  input  logic             acquire_i,
  input  logic             qual_xfer_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_zero_o
);
  import bhl_pkg::*;

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  cnt_act_e         action;

  assign at_zero_o = (cnt_q == '0);
  assign action    = bhl_pick_action(req_level_i, acquire_i, qual_xfer_i,
                                     enabled_i, at_zero_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (action)
        CA_LOAD: cnt_q <= limit_i;
        CA_DEC:  cnt_q <= cnt_q - STEP;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;

  p_acquire_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_level_i && acquire_i) |=> (count_o == $past(limit_i)));

  p_drop_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_level_i |=> (count_o == $past(limit_i)));

  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_level_i && !acquire_i && qual_xfer_i && enabled_i && count_o != '0)
      |=> (count_o == $past(count_o) - STEP));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_level_i && !acquire_i && !qual_xfer_i) |=> $stable(count_o));

endmodule

// File: rtl/bhl_release.sv
module bhl_release (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enabled_i,
  input  logic req_level_i,
  input  logic acquire_i,
  input  logic qual_xfer_i,
  input  logic at_zero_i,
  output logic release_o
);
  import bhl_pkg::*;

  logic expired;
  logic held_q;

  assign expired = bhl_expired(req_level_i, acquire_i, qual_xfer_i,
                               enabled_i, at_zero_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          held_q <= 1'b0;
    else if (!req_level_i) held_q <= 1'b0;
    else if (expired)      held_q <= 1'b1;
  end

  assign release_o = req_level_i && (expired || held_q);

  p_release_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (!req_level_i || release_o));

  p_release_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_level_i |-> !release_o);

  p_release_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> (at_zero_i && qual_xfer_i && enabled_i));

endmodule

// File: rtl/bus_hold_limiter.sv
module bus_hold_limiter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             acquire_i,
  input  logic             xfer_i,
  input  logic             others_req_i,
  input  logic             req_level_i,
  output logic [CNT_W-1:0] count_o,
  output logic             release_o
);

  logic [CNT_W-1:0] limit_w;
  logic [CNT_W-1:0] count_w;
  logic             enabled_w;
  logic             qual_xfer_w;
  logic             at_zero_w;

  assign qual_xfer_w = xfer_i && others_req_i;

  bhl_limit_reg #(.CNT_W(CNT_W)) u_limit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .limit_o   (limit_w),
    .enabled_o (enabled_w)
  );

  bhl_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .limit_i     (limit_w),
    .enabled_i   (enabled_w),
    .req_level_i (req_level_i),
    .acquire_i   (acquire_i),
    .qual_xfer_i (qual_xfer_w),
    .count_o     (count_w),
    .at_zero_o   (at_zero_w)
  );

  bhl_release u_release (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enabled_i   (enabled_w),
    .req_level_i (req_level_i),
    .acquire_i   (acquire_i),
    .qual_xfer_i (qual_xfer_w),
    .at_zero_i   (at_zero_w),
    .release_o   (release_o)
  );

  assign count_o   = count_w;
  assign rd_data_o = rd_sel_i ? count_w : limit_w;

  p_disabled_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_w == '0) |-> !release_o);

  p_readback_mux_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> (rd_data_o == count_o));

endmodule

// File: tb/bus_hold_limiter_tb.sv
module bus_hold_limiter_tb_top;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             rd_sel_i = 1'b0;
  logic [CNT_W-1:0] rd_data_o;
  logic             acquire_i = 1'b0;
  logic             xfer_i = 1'b0;
  logic             others_req_i = 1'b0;
  logic             req_level_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             release_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_hold_limiter #(.CNT_W(CNT_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o),
    .acquire_i    (acquire_i),
    .xfer_i       (xfer_i),
    .others_req_i (others_req_i),
    .req_level_i  (req_level_i),
    .count_o      (count_o),
    .release_o    (release_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs change and checks are taken 2 ns after each rising edge.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic read_limit(input string req, input int exp);
    rd_sel_i = 1'b0; #1;
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic read_count(input string req, input int exp);
    rd_sel_i = 1'b1; #1;
    chk(req, int'(rd_data_o), exp);
    chk(req, int'(count_o), exp);
  endtask

  task automatic write_limit(input int value);
    wr_en_i = 1'b1; wr_data_i = CNT_W'(value);
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic grab_bus();
    req_level_i = 1'b1; acquire_i = 1'b1;
    tick();
    acquire_i = 1'b0;
  endtask

  task automatic drop_bus();
    xfer_i = 1'b0; others_req_i = 1'b0; req_level_i = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    read_limit("R1 limit after reset", 0);
    read_count("R1 count after reset", 0);
    chk("R1 release after reset", int'(release_o), 0);
  endtask

  task automatic t_register_port();
    write_limit(5);
    read_limit("R2 write 5", 5);
    write_limit(1);
    read_limit("R3 write of 1 refused", 5);
    write_limit(0);
    read_limit("R2 write 0", 0);
    write_limit(1);
    read_limit("R3 refused over 0", 0);
    write_limit(700);
    read_limit("R2 write 700", 700);
    read_count("R10 count select", 0);
  endtask

  task automatic t_countdown();
    write_limit(3);
    grab_bus();
    read_count("R4 load on acquire", 3);
    xfer_i = 1'b1; others_req_i = 1'b0;
    tick(); tick();
    read_count("R5 no requester holds", 3);
    xfer_i = 1'b0; others_req_i = 1'b1;
    tick();
    read_count("R5 requester without transfer holds", 3);
    xfer_i = 1'b1;
    for (int k = 2; k >= 0; k--) begin
      chk("R7 no release while budget left", int'(release_o), 0);
      tick();
      read_count("R5 step down", k);
    end
    #1;
    chk("R7 release at exhaustion", int'(release_o), 1);
    tick();
    xfer_i = 1'b0; others_req_i = 1'b0; #1;
    chk("R8 release sticky", int'(release_o), 1);
    read_count("R5 count floors at zero", 0);
    tick();
    chk("R8 release still sticky", int'(release_o), 1);
    req_level_i = 1'b0; #1;
    chk("R8 release drops with request", int'(release_o), 0);
    tick();
    read_count("R6 reload on request drop", 3);
    chk("R8 release stays low", int'(release_o), 0);
  endtask

  task automatic t_drop_mid_run();
    write_limit(4);
    grab_bus();
    xfer_i = 1'b1; others_req_i = 1'b1;
    tick(); tick();
    read_count("R5 two steps", 2);
    drop_bus();
    read_count("R6 reload mid run", 4);
    grab_bus();
    read_count("R4 reacquire load", 4);
    drop_bus();
  endtask

  task automatic t_minimum_limit();
    int held = 0;
    write_limit(2);
    grab_bus();
    held = 1;
    xfer_i = 1'b1; others_req_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1;
      held++;
      if (release_o) break;
      tick();
    end
    chk("R7 limit 2 holds four cycles", held, 4);
    drop_bus();
  endtask

  task automatic t_disabled();
    write_limit(0);
    grab_bus();
    read_count("R9 disabled load", 0);
    xfer_i = 1'b1; others_req_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (release_o) chk("R9 no release when disabled", 1, 0);
      tick();
    end
    chk("R9 release idle", int'(release_o), 0);
    read_count("R9 count stays zero", 0);
    drop_bus();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_ni = 1'b1;
    t_reset();
    t_register_port();
    t_countdown();
    t_drop_mid_run();
    t_minimum_limit();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule